// File: doc/BRIEF.md
# Three-Common LCD Multiplex Waveform Generator

This block turns a latched image of 156 display bits into multiplexed drive levels for a panel with three common electrodes and 52 segment electrodes at 1/3 duty. Each output carries a level code for an external analog stage, which converts the code into a voltage between ground and full scale. A frame has six time slots. Each common is selected once with normal polarity and then once with inverted polarity, so the panel sees no net DC voltage.

Control inputs select 1/2 or 1/3 bias, blank all segments, and enter a power-saving state. In the power-saving state the slot timer stops and all outputs go to ground. A separate active-low inhibit input also forces every output to ground. It is used while the display image is still undefined after power-up.

The segment-to-bit mapping is not linear. Most segments read three consecutive bits. The bits that belong to segment 42 sit below the block used by segments 33 to 41.

Top module: `lcdMuxDrive`

## Requirements
- R1: Segment s (0-based) reads three consecutive bits starting at `dispBits` index 3s, except for two ranges. Segments 32 to 40 start at index 3s+3. Segment 41 starts at index 96. Within a segment's three bits, the offset is the common index (0, 1 or 2).
- R2: The active common advances every SLOT_CLKS clocks. Six slots form a frame: commons 0, 1 and 2 with normal polarity, then commons 0, 1 and 2 with inverted polarity. The frame then repeats.
- R3: Level codes are 0 = ground, 1 = one third, 2 = half, 3 = two thirds and 4 = full scale. Common c sits at `comLevel[3c+2:3c]` and segment s at `segLevel[3s+2:3s]`. With `halfBias` low, the levels are as follows:
  - The selected common drives 4 in a normal slot and 0 in an inverted slot.
  - An unselected common drives 1 in a normal slot and 3 in an inverted slot.
  - An on segment drives 0 in a normal slot and 4 in an inverted slot.
  - An off segment drives 3 in a normal slot and 1 in an inverted slot.
- R4: With `halfBias` high, the selected common and on segments drive the same extremes as in R3. Unselected commons and off segments drive 2.
- R5: While `blankSegs` is high, every segment is driven as off, whatever the display bits hold. The commons keep their normal waveform.
- R6: While `sleepEn` is high, all outputs are 0 and the slot timer is held at its start. After `sleepEn` falls, the waveform restarts from common 0, normal polarity, with a full slot.
- R7: While `inhibitN` is low, all outputs are 0. The slot timer keeps running.
- R8: After reset, the block is in the first clock of common 0's normal slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dispBits | input | 156 | Latched display image; bit i is display bit i+1 |
| halfBias | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| blankSegs | input | 1 | 1 forces all segments off |
| sleepEn | input | 1 | 1 enters power saving |
| inhibitN | input | 1 | 0 forces all outputs to ground |
| comLevel | output | 9 | Three 3-bit common level codes |
| segLevel | output | 156 | Fifty-two 3-bit segment level codes |

## Verification
The situation that is hardest to reach is a sleep request that lands partway through a slot in the inverted half-frame. The restart to common 0 with normal polarity and a full-length slot only shows after the request is released. To reach it, the stimulus first runs the timer to an inverted slot and raises `sleepEn` there. It drops `sleepEn` a few clocks later and then compares every clock of the following frame against a behavioural model of the slot timer. Single-bit images at the segment 41/42 boundary are also applied, so that the irregular mapping is seen on the pins.

// File: rtl/lcdMuxPkg.sv
package lcdMuxPkg;
  localparam int NUM_COM = 3;
  localparam int SLOT_W  = 2;

  typedef enum logic [2:0] {
    LVL_GND   = 3'd0,
    LVL_THIRD = 3'd1,
    LVL_HALF  = 3'd2,
    LVL_TWO3  = 3'd3,
    LVL_FULL  = 3'd4
  } lvl_e;

  // Strobes handed from the slot timer to the level datapath
  typedef struct packed {
    logic [SLOT_W-1:0] slot;    // active common
    logic              invert;  // second half of the frame
    logic              quiet;   // force every output to ground
  } phaseStrb_t;

  // First display-bit index (0-based) of a segment's trio
  function automatic int trioBase(input int seg);
    if (seg >= 32 && seg <= 40) return 3 * seg + 3;
    else if (seg == 41)         return 96;
    else                        return 3 * seg;
  endfunction
endpackage

// File: rtl/lcdMuxCtrl.sv
module lcdMuxCtrl
  import lcdMuxPkg::*;
#(
  parameter int SLOT_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepEn,
  input  logic       inhibitN,
  output phaseStrb_t strb
);
  localparam int CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SLOT_CLKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_COM - 1);

  logic [CNT_W-1:0]  tickCnt;
  logic [SLOT_W-1:0] slotIdx;
  logic              invPhase;
  logic              slotEnd;

  assign slotEnd = (tickCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      slotIdx  <= '0;
      invPhase <= 1'b0;
    end else if (sleepEn) begin
      tickCnt  <= '0;
      slotIdx  <= '0;
      invPhase <= 1'b0;
    end else if (slotEnd) begin
      tickCnt <= '0;
      if (slotIdx == SLOT_LAST) begin
        slotIdx  <= '0;
        invPhase <= ~invPhase;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strb.slot   = slotIdx;
    strb.invert = invPhase;
    strb.quiet  = sleepEn | ~inhibitN;
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    slotIdx <= SLOT_LAST); // R2

  AST_SLEEP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    sleepEn |=> (tickCnt == '0 && slotIdx == '0 && !invPhase)); // R6

  AST_HALF_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepEn && slotEnd && slotIdx == SLOT_LAST) |=>
      (slotIdx == '0 && invPhase != $past(invPhase))); // R2

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepEn && !slotEnd) |=> $stable(slotIdx)); // R2
endmodule

// File: rtl/lcdMuxDatapath.sv
module lcdMuxDatapath
  import lcdMuxPkg::*;
#(
  parameter int NUM_SEG = 52
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [3*NUM_SEG-1:0]   dispBits,
  input  logic                   halfBias,
  input  logic                   blankSegs,
  input  phaseStrb_t             strb,
  output logic [3*NUM_COM-1:0]   comLevel,
  output logic [3*NUM_SEG-1:0]   segLevel
);
  logic [NUM_COM-1:0] comExtreme;
  logic [NUM_SEG-1:0] segExtreme;
  logic [NUM_COM-1:0] comThird;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    lvl_e comLvl;
    always_comb begin
      if (strb.quiet)                    comLvl = LVL_GND;
      else if (strb.slot == SLOT_W'(c))  comLvl = strb.invert ? LVL_GND : LVL_FULL;
      else if (halfBias)                 comLvl = LVL_HALF;
      else                               comLvl = strb.invert ? LVL_TWO3 : LVL_THIRD;
    end
    assign comLevel[3*c +: 3] = comLvl;
    assign comExtreme[c] = (comLevel[3*c +: 3] == LVL_FULL) || (comLevel[3*c +: 3] == LVL_GND);
    assign comThird[c]   = (comLevel[3*c +: 3] == LVL_THIRD) || (comLevel[3*c +: 3] == LVL_TWO3);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int BASE = trioBase(s);
    logic [3:0] trio;
    logic       pixOn;
    lvl_e       segLvl;
    assign trio  = {1'b0, dispBits[BASE +: 3]};
    assign pixOn = trio[strb.slot] & ~blankSegs;
    always_comb begin
      if (strb.quiet)    segLvl = LVL_GND;
      else if (pixOn)    segLvl = strb.invert ? LVL_FULL : LVL_GND;
      else if (halfBias) segLvl = LVL_HALF;
      else               segLvl = strb.invert ? LVL_THIRD : LVL_TWO3;
    end
    assign segLevel[3*s +: 3] = segLvl;
    assign segExtreme[s] = (segLevel[3*s +: 3] == LVL_FULL) || (segLevel[3*s +: 3] == LVL_GND);
  end

  AST_QUIET_GROUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.quiet |-> (comLevel == '0 && segLevel == '0)); // R7

  AST_ONE_SELECTED_COM: assert property (@(posedge clk) disable iff (!rstN)
    !strb.quiet |-> $countones(comExtreme) == 1); // R2

  AST_HALF_NO_THIRDS: assert property (@(posedge clk) disable iff (!rstN)
    (halfBias && !strb.quiet) |-> comThird == '0); // R4

  AST_BLANK_NO_EXTREME: assert property (@(posedge clk) disable iff (!rstN)
    (blankSegs && !strb.quiet) |-> segExtreme == '0); // R5
endmodule

// File: rtl/lcdMuxDrive.sv
module lcdMuxDrive
  import lcdMuxPkg::*;
#(
  parameter int SLOT_CLKS = 4,
  parameter int NUM_SEG   = 52
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3*NUM_SEG-1:0] dispBits,
  input  logic                 halfBias,
  input  logic                 blankSegs,
  input  logic                 sleepEn,
  input  logic                 inhibitN,
  output logic [3*NUM_COM-1:0] comLevel,
  output logic [3*NUM_SEG-1:0] segLevel
);
  phaseStrb_t strb;

  lcdMuxCtrl #(.SLOT_CLKS(SLOT_CLKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepEn  (sleepEn),
    .inhibitN (inhibitN),
    .strb     (strb)
  );

  lcdMuxDatapath #(.NUM_SEG(NUM_SEG)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dispBits  (dispBits),
    .halfBias  (halfBias),
    .blankSegs (blankSegs),
    .strb      (strb),
    .comLevel  (comLevel),
    .segLevel  (segLevel)
  );
endmodule

// File: tb/lcdMuxDrive_bench.sv
`timescale 1ns/1ps
module lcdMuxDrive_bench;
  localparam int SLOTS = 4;
  localparam int NSEG  = 52;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [155:0]    dispBits = '0;
  logic            halfBias = 1'b0;
  logic            blankSegs = 1'b0;
  logic            sleepEn = 1'b0;
  logic            inhibitN = 1'b1;
  logic [8:0]      comLevel;
  logic [155:0]    segLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model of the slot timer
  int mCnt = 0, mSlot = 0, mInv = 0;

  always #5 clk = ~clk;

  lcdMuxDrive u_lcdMuxDrive (
    .clk(clk), .rstN(rstN), .dispBits(dispBits), .halfBias(halfBias),
    .blankSegs(blankSegs), .sleepEn(sleepEn), .inhibitN(inhibitN),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  always @(posedge clk) begin
    if (!rstN || sleepEn) begin
      mCnt = 0; mSlot = 0; mInv = 0;
    end else begin
      mCnt++;
      if (mCnt == SLOTS) begin
        mCnt = 0;
        mSlot++;
        if (mSlot == 3) begin mSlot = 0; mInv = 1 - mInv; end
      end
    end
  end

  // R1: display-bit index for segment seg, common com (both 0-based)
  function automatic int bitOf(int seg, int com);
    int base;
    if (seg == 41) base = 96;
    else if (seg < 32 || seg > 41) base = seg * 3;
    else base = seg * 3 + 3;
    return base + com;
  endfunction

  function automatic int expCom(int k);
    if (sleepEn || !inhibitN) return 0;
    if (k == mSlot) return mInv ? 0 : 4;
    if (halfBias) return 2;
    return mInv ? 3 : 1;
  endfunction

  function automatic int expSeg(int s);
    bit on;
    if (sleepEn || !inhibitN) return 0;
    on = !blankSegs && dispBits[bitOf(s, mSlot)];
    if (on) return mInv ? 4 : 0;
    if (halfBias) return 2;
    return mInv ? 1 : 3;
  endfunction

  function automatic string tagNow();
    if (sleepEn) return "R6";
    if (!inhibitN) return "R7";
    if (blankSegs) return "R5";
    if (halfBias) return "R4/R1";
    return "R3/R1";
  endfunction

  task automatic compareAll();
    logic [8:0]   eCom;
    logic [155:0] eSeg;
    for (int k = 0; k < 3; k++) eCom[3*k +: 3] = 3'(expCom(k));
    for (int s = 0; s < NSEG; s++) eSeg[3*s +: 3] = 3'(expSeg(s));
    checks++;
    if (comLevel !== eCom) begin
      fails++;
      $display("FAIL %s/R2 commons: actual %h expected %h (slot %0d inv %0d)",
               tagNow(), comLevel, eCom, mSlot, mInv);
    end
    checks++;
    if (segLevel !== eSeg) begin
      fails++;
      $display("FAIL %s segments: actual %h expected %h (slot %0d inv %0d)",
               tagNow(), segLevel, eSeg, mSlot, mInv);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    dispBits = {52{3'b101}};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: first slot of common 0, normal polarity, right after reset
    checks++;
    if (comLevel !== 9'({3'd1, 3'd1, 3'd4})) begin
      fails++;
      $display("FAIL R8 reset state: actual %h expected %h", comLevel, 9'({3'd1, 3'd1, 3'd4}));
    end
    // R2/R3: two frames at 1/3 bias, several images
    run(24);
    dispBits = {156{1'b1}};
    run(24);
    for (int p = 0; p < 4; p++) begin
      dispBits = {$urandom, $urandom, $urandom, $urandom, $urandom};
      run(12);
    end
    // R1: single bits around the irregular block
    for (int b = 93; b < 130; b++) begin
      dispBits = '0;
      dispBits[b] = 1'b1;
      run(3);
    end
    // R4: half bias
    halfBias = 1'b1;
    dispBits = {$urandom, $urandom, $urandom, $urandom, $urandom};
    run(24);
    // R5: blanking with a full image
    dispBits = {156{1'b1}};
    blankSegs = 1'b1;
    run(24);
    blankSegs = 1'b0;
    halfBias = 1'b0;
    // R6: sleep entered in an inverted slot, mid-slot
    while (!(mInv == 1 && mSlot == 1 && mCnt == 2)) run(1);
    sleepEn = 1'b1;
    run(5);
    sleepEn = 1'b0;
    run(30);
    // R7: inhibit while the timer keeps running
    inhibitN = 1'b0;
    run(7);
    inhibitN = 1'b1;
    run(30);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule